// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Arbiter

The arbiter collects pending flags from a parameterised set of interrupt sources, picks the one with the lowest slot index among those currently eligible, and raises a single request towards the processor. Slot indexes below a fixed boundary belong to non-maskable sources such as reset and the software trap. These are eligible whenever pending. Every other slot is eligible only when its local enable is set and the global interrupt mask is clear. A peripheral that needs several vectors simply occupies several adjacent slots.

When a request is raised, the chosen slot is captured and held. Later higher-priority arrivals do not change it until the processor acknowledges. The vector address for slot k is the top-of-memory address minus twice k. It is offered as a full 16-bit word and also as a byte lane, high byte first, for a processor that fetches the vector one byte at a time. On acknowledge, the arbiter pulses a request for the processor to set its interrupt mask. It also blocks maskable sources internally until the processor's mask input has been seen high, so a nested maskable interrupt cannot slip in before the mask takes effect.

Top module: `irq_vec_arb`

## Requirements
- R1: After reset, irq_o is 0, ibit_set_o is 0 and vec_o is 0xFFFE (slot 0).
- R2: Among eligible sources, the lowest slot index is granted first; a lower index means higher priority.
- R3: Slots below N_FIXED (default 2: slot 0 reset, slot 1 software trap) are eligible whenever pending, regardless of en_i and gmask_i.
- R4: A slot at or above N_FIXED is eligible only when its en_i bit is 1 and the effective mask (gmask_i or the internal post-acknowledge block) is 0.
- R5: The vector for granted slot k is VEC_TOP - 2k, with VEC_TOP defaulting to 0xFFFE; slot 15 gives 0xFFE0.
- R6: vec_byte_o carries vec_o[15:8] when byte_sel_i is 0 and vec_o[7:0] when byte_sel_i is 1.
- R7: irq_o rises one cycle after an eligible source is seen while idle. It then stays 1 with vec_o unchanged until ack_i is sampled high, even if a higher-priority source arrives meanwhile.
- R8: When ack_i is sampled high while irq_o is 1, irq_o is 0 and ibit_set_o is 1 in the next cycle, and ibit_set_o returns to 0 the cycle after.
- R9: After an acknowledge, maskable slots stay blocked until gmask_i has been sampled high; non-maskable slots are still granted during the block.
- R10: ack_i while irq_o is 0 has no effect: no ibit_set_o pulse and no maskable block.
- R11: With no eligible source, irq_o stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | N_SRC | Pending flag per slot |
| en_i | input | N_SRC | Local enable per slot (ignored for non-maskable slots) |
| gmask_i | input | 1 | Global interrupt mask from the processor, 1 = masked |
| ack_i | input | 1 | Processor acknowledge of the current request |
| byte_sel_i | input | 1 | Vector byte lane select, 0 = high byte, 1 = low byte |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 16 | Vector address of the granted slot |
| vec_byte_o | output | 8 | Selected byte of the vector |
| ibit_set_o | output | 1 | One-cycle pulse asking the processor to set its mask |

## Verification
On every cycle, the assertions check several properties. A raised request must hold its vector until acknowledged. An acknowledge must drop the request and give a single-cycle mask pulse, while a stray acknowledge must give none. A freshly granted slot must have been pending. A maskable grant must have seen its enable set and the effective mask clear. A pending non-maskable slot must win the next arbitration. The vector must stay even-aligned and in range. Only the bench scenarios can show the rest. These cover the full grant order across several simultaneous sources, the exact vector and byte-lane values per slot, and the post-acknowledge block lifting only after the mask input pulses high.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = ADDR_W / 2;
  localparam int unsigned MAX_SRC = 128;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_REQ  = 1'b1
  } arb_st_e;
endpackage

// File: rtl/irq_elig.sv
module irq_elig #(
  parameter int unsigned N_SRC   = 16,
  parameter int unsigned N_FIXED = 2,
  localparam int unsigned N_MSK  = N_SRC - N_FIXED
) (
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_MSK-1:0] en_i,
  input  logic             mask_i,
  output logic [N_SRC-1:0] elig_o
);
  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    if (k < N_FIXED) begin : g_fix
      assign elig_o[k] = pend_i[k];
    end else begin : g_msk
      assign elig_o[k] = pend_i[k] & en_i[k-N_FIXED] & ~mask_i;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N_SRC = 16,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  // scan from the bottom of the order upward so the lowest index overwrites last
  always_comb begin
    valid_o = |req_i;
    idx_o   = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = IDX_W'(k);
    end
  end
endmodule

// File: rtl/irq_grant_ctl.sv
module irq_grant_ctl
  import irq_arb_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             ack_i,
  input  logic             gmask_i,
  output logic             irq_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             ibit_set_o,
  output logic             hold_o
);
  arb_st_e          st_q;
  logic [IDX_W-1:0] idx_q;
  logic             ibit_q;
  logic             hold_q;
  logic             take_ack;

  assign take_ack = (st_q == ST_REQ) && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      ibit_q <= 1'b0;
    end else begin
      ibit_q <= take_ack;
      unique case (st_q)
        ST_IDLE: if (valid_i) begin
          idx_q <= idx_i;
          st_q  <= ST_REQ;
        end
        ST_REQ: if (ack_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // block maskable slots after ack until the CPU mask is seen high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hold_q <= 1'b0;
    else if (take_ack) hold_q <= 1'b1;
    else if (gmask_i)  hold_q <= 1'b0;
  end

  assign irq_o      = (st_q == ST_REQ);
  assign idx_o      = idx_q;
  assign ibit_set_o = ibit_q;
  assign hold_o     = hold_q;

  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> (irq_o && $stable(idx_o)));

  p_ack_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_i) |=> (!irq_o && ibit_set_o));

  p_ibit_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ibit_set_o |=> !ibit_set_o);

  p_stray_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && ack_i) |=> !ibit_set_o);
endmodule

// File: rtl/irq_vec_arb.sv
module irq_vec_arb
  import irq_arb_pkg::*;
#(
  parameter int unsigned       N_SRC   = 16,
  parameter int unsigned       N_FIXED = 2,
  parameter logic [ADDR_W-1:0] VEC_TOP = 16'hFFFE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  pend_i,
  input  logic [N_SRC-1:0]  en_i,
  input  logic              gmask_i,
  input  logic              ack_i,
  input  logic              byte_sel_i,
  output logic              irq_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic [BYTE_W-1:0] vec_byte_o,
  output logic              ibit_set_o
);
  localparam int unsigned IDX_W = $clog2(N_SRC);
  localparam int unsigned PAD_W = ADDR_W - IDX_W - 1;
  localparam logic [ADDR_W-1:0] VEC_LOW = VEC_TOP - ADDR_W'(2 * (N_SRC - 1));

  logic [N_SRC-1:0] elig;
  logic             enc_valid;
  logic [IDX_W-1:0] enc_idx;
  logic [IDX_W-1:0] grant_idx;
  logic             hold;
  logic             mask_eff;

  assign mask_eff = gmask_i | hold;

  irq_elig #(
    .N_SRC  (N_SRC),
    .N_FIXED(N_FIXED)
  ) u_elig (
    .pend_i(pend_i),
    .en_i  (en_i[N_SRC-1:N_FIXED]),
    .mask_i(mask_eff),
    .elig_o(elig)
  );

  irq_prio_enc #(
    .N_SRC(N_SRC)
  ) u_enc (
    .req_i  (elig),
    .valid_o(enc_valid),
    .idx_o  (enc_idx)
  );

  irq_grant_ctl #(
    .IDX_W(IDX_W)
  ) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (enc_valid),
    .idx_i     (enc_idx),
    .ack_i     (ack_i),
    .gmask_i   (gmask_i),
    .irq_o     (irq_o),
    .idx_o     (grant_idx),
    .ibit_set_o(ibit_set_o),
    .hold_o    (hold)
  );

  assign vec_o      = VEC_TOP - {{PAD_W{1'b0}}, grant_idx, 1'b0};
  assign vec_byte_o = byte_sel_i ? vec_o[BYTE_W-1:0] : vec_o[ADDR_W-1:BYTE_W];

  // one-cycle delayed copies of the inputs, used only by the checks below
  logic [N_SRC-1:0] pend_d;
  logic [N_SRC-1:0] en_d;
  logic             mask_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_d <= '0;
      en_d   <= '0;
      mask_d <= 1'b1;
    end else begin
      pend_d <= pend_i;
      en_d   <= en_i;
      mask_d <= mask_eff;
    end
  end

  p_grant_pending_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> pend_d[grant_idx]);

  // also covers R9: mask_d includes the post-acknowledge block
  p_mask_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) && (32'(grant_idx) >= N_FIXED)) |-> (en_d[grant_idx] && !mask_d));

  p_fixed_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && (|pend_i[N_FIXED-1:0])) |=> (irq_o && (32'(grant_idx) < N_FIXED)));

  p_vec_align_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!vec_o[0] && vec_o <= VEC_TOP && vec_o >= VEC_LOW));
endmodule

// File: tb/irq_vec_arb_test.sv
module irq_vec_arb_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int WDOG_CYCLES = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] pend;
  logic [N-1:0] en_r = '1;
  logic        gm_drv = 1'b0;
  logic        rti = 1'b0;
  logic        ack_mon = 1'b0;
  logic        ack_drv = 1'b0;
  logic        bsel = 1'b0;
  logic        irq_o;
  logic [15:0] vec_o;
  logic [7:0]  vec_byte_o;
  logic        ibit_set_o;

  int req_cnt [N];
  int svc_cnt [N];
  logic [15:0] exp_q [$];
  int checks = 0;
  int fails = 0;
  int grants = 0;
  int ack_delay = 0;
  bit auto_rti = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int k = 0; k < N; k++) pend[k] = (req_cnt[k] != svc_cnt[k]);
  end

  irq_vec_arb uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .pend_i    (pend),
    .en_i      (en_r),
    .gmask_i   (gm_drv | rti),
    .ack_i     (ack_mon | ack_drv),
    .byte_sel_i(bsel),
    .irq_o     (irq_o),
    .vec_o     (vec_o),
    .vec_byte_o(vec_byte_o),
    .ibit_set_o(ibit_set_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic raise(input int k);
    req_cnt[k]++;
  endtask

  task automatic wait_grants(input int target);
    while (grants < target) @(negedge clk);
  endtask

  function automatic logic [15:0] vec_of(input int k);
    return 16'hFFFE - 16'(2 * k);
  endfunction

  // monitor: plays the CPU, pops expected vectors and acknowledges
  initial begin
    logic [15:0] e;
    int k;
    forever begin
      @(negedge clk);
      if (rst_n && irq_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected grant", vec_o, 0);
          e = vec_o;
        end else begin
          e = exp_q.pop_front();
          chk(vec_o == e, "R2 R5 grant vector", vec_o, e);
        end
        bsel = 1'b0; #1;
        chk(vec_byte_o == e[15:8], "R6 high byte", vec_byte_o, e[15:8]);
        bsel = 1'b1; #1;
        chk(vec_byte_o == e[7:0], "R6 low byte", vec_byte_o, e[7:0]);
        bsel = 1'b0;
        for (int i = 0; i < ack_delay; i++) begin
          @(negedge clk);
          chk(irq_o && vec_o == e, "R7 request and vector held", vec_o, e);
        end
        k = int'((16'hFFFE - e) >> 1);
        ack_mon = 1'b1;
        svc_cnt[k]++;
        @(negedge clk);
        ack_mon = 1'b0;
        chk(!irq_o, "R8 request dropped", irq_o, 0);
        chk(ibit_set_o, "R8 mask-set pulse", ibit_set_o, 1);
        if (auto_rti) rti = 1'b1;
        @(negedge clk);
        rti = 1'b0;
        chk(!ibit_set_o, "R8 pulse single cycle", ibit_set_o, 0);
        grants++;
      end
    end
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    for (int k = 0; k < N; k++) begin
      req_cnt[k] = 0;
      svc_cnt[k] = 0;
    end
    repeat (3) @(negedge clk);
    chk(!irq_o, "R1 reset irq", irq_o, 0);
    chk(vec_o == 16'hFFFE, "R1 reset vector", vec_o, 16'hFFFE);
    chk(!ibit_set_o, "R1 reset pulse", ibit_set_o, 0);
    rst_n = 1'b1;

    // R11: idle with nothing pending
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!irq_o, "R11 idle", irq_o, 0);
    end

    // R4 R5: single maskable slot
    exp_q.push_back(vec_of(5));
    raise(5);
    wait_grants(1);

    // R2: three at once, served in index order
    @(negedge clk);
    exp_q.push_back(vec_of(3));
    exp_q.push_back(vec_of(7));
    exp_q.push_back(vec_of(12));
    raise(12); raise(7); raise(3);
    wait_grants(4);

    // R4: local enable off blocks
    @(negedge clk);
    en_r[9] = 1'b0;
    raise(9);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!irq_o, "R4 local enable off", irq_o, 0);
    end
    exp_q.push_back(16'hFFEC);
    en_r[9] = 1'b1;
    wait_grants(5);

    // R4 global mask blocks; R3 software trap passes with enable off
    @(negedge clk);
    gm_drv = 1'b1;
    raise(4);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!irq_o, "R4 global mask", irq_o, 0);
    end
    en_r[1] = 1'b0;
    exp_q.push_back(16'hFFFC);
    raise(1);
    wait_grants(6);
    @(negedge clk);
    req_cnt[4]--;
    en_r[1] = 1'b1;
    gm_drv = 1'b0;

    // R3: reset slot with mask set and enable off
    @(negedge clk);
    en_r[0] = 1'b0;
    gm_drv = 1'b1;
    exp_q.push_back(16'hFFFE);
    raise(0);
    wait_grants(7);
    @(negedge clk);
    en_r[0] = 1'b1;
    gm_drv = 1'b0;

    // R7: higher priority arriving while a grant is held
    ack_delay = 4;
    exp_q.push_back(vec_of(10));
    raise(10);
    while (!irq_o) @(negedge clk);
    @(negedge clk);
    exp_q.push_back(16'hFFFE);
    raise(0);
    wait_grants(9);
    ack_delay = 0;

    // R9: block after acknowledge until mask seen high
    @(negedge clk);
    auto_rti = 1'b0;
    exp_q.push_back(vec_of(6));
    raise(6);
    wait_grants(10);
    @(negedge clk);
    raise(8);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!irq_o, "R9 maskable blocked after ack", irq_o, 0);
    end
    exp_q.push_back(16'hFFFC);
    raise(1);
    wait_grants(11);
    @(negedge clk);
    chk(!irq_o, "R9 still blocked", irq_o, 0);
    gm_drv = 1'b1;
    @(negedge clk);
    gm_drv = 1'b0;
    auto_rti = 1'b1;
    exp_q.push_back(16'hFFEE);
    wait_grants(12);

    // R10: stray acknowledge
    @(negedge clk);
    ack_drv = 1'b1;
    @(negedge clk);
    ack_drv = 1'b0;
    chk(!ibit_set_o, "R10 no pulse on stray ack", ibit_set_o, 0);
    chk(!irq_o, "R10 no request on stray ack", irq_o, 0);
    exp_q.push_back(16'hFFE4);
    raise(13);
    @(negedge clk);
    chk(irq_o, "R10 maskable not blocked", irq_o, 1);
    wait_grants(13);

    // R5: highest slot
    @(negedge clk);
    exp_q.push_back(16'hFFE0);
    raise(15);
    wait_grants(14);

    // R2 R3: non-maskable beats maskable neighbour
    @(negedge clk);
    exp_q.push_back(16'hFFFC);
    exp_q.push_back(16'hFFFA);
    raise(2); raise(1);
    wait_grants(16);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all expected grants seen", exp_q.size(), 0);
    chk(!irq_o, "R11 idle at end", irq_o, 0);
    report();
  end
endmodule